// File: doc/BRIEF.md
# Bidirectional Universal Shift Register with Shared Parallel Bus

This block is a parameterised register, eight bits by default, that can keep its contents, move them one place toward the high end or toward the low end, or take a new word in parallel. A two-bit select input picks the operation. Every change happens on the rising clock edge. An active-low clear, also sampled on that edge, empties the register whatever the select input says.

Parallel data uses a single bidirectional bus, modelled here as an input vector, an output vector and one drive-enable. The register always presents its contents on the output vector. The drive-enable is high only when both active-low enables are low and the block is not in load mode. In load mode the bus is released, so an external source can drive the word that is about to be captured. Releasing the bus never stops the register from working.

Each end of the register has its own serial input. The lowest and highest bits also appear on dedicated tap outputs that are always driven. Wiring the high tap of one instance to the low serial input of the next, and the low tap of the next back to the high serial input of the first, builds a wider shifter. The parallel bus and the serial ends have no valid/ready handshake and no back-pressure. The register accepts whatever is on its inputs at every clock edge, and the serial chain depends on that fixed one-word-per-edge timing.

Top module: `bidir_shift_reg`

## Requirements
- R1: When clr_n is 0 at a rising clock edge, every register bit becomes 0 after that edge, whatever the values of sel, bus_in and the serial inputs.
- R2: With clr_n = 1 and sel = 2'b00 (hold), the register keeps its value across the edge, and changes on bus_in or the serial inputs have no effect.
- R3: With clr_n = 1 and sel = 2'b01 (move up), bit n+1 takes the old bit n, and bit 0 takes ser_in_lo.
- R4: With clr_n = 1 and sel = 2'b10 (move down), bit n-1 takes the old bit n, and bit W-1 takes ser_in_hi.
- R5: With clr_n = 1 and sel = 2'b11 (load), the register takes bus_in.
- R6: bus_oe is combinational and equals 1 only when oe_a_n = 0, oe_b_n = 0 and sel is not 2'b11. Otherwise it is 0 and the bus is released.
- R7: bus_out always equals the register contents, tap_lo equals bit 0 and tap_hi equals bit W-1. All three are independent of oe_a_n, oe_b_n and bus_oe.
- R8: Clear, hold, move and load give the same results when the bus is released by either enable.
- R9: Two instances joined tap_hi to ser_in_lo and tap_lo to ser_in_hi, with shared clock and select, act as one 2W-bit register in both shift directions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Synchronous clear, active low, overrides sel |
| sel | input | 2 | Operation: 00 hold, 01 move up, 10 move down, 11 load |
| ser_in_lo | input | 1 | Serial bit entering bit 0 when moving up |
| ser_in_hi | input | 1 | Serial bit entering bit W-1 when moving down |
| oe_a_n | input | 1 | Bus drive enable A, active low |
| oe_b_n | input | 1 | Bus drive enable B, active low |
| bus_in | input | W | Value seen on the shared bus, captured on load |
| bus_out | output | W | Register contents offered to the shared bus |
| bus_oe | output | 1 | Shared bus drive-enable |
| tap_lo | output | 1 | Always-driven copy of bit 0 |
| tap_hi | output | 1 | Always-driven copy of bit W-1 |

## Verification
The bench builds two instances with the default width of eight. Used alone, the first instance covers every operation, clear priority over load and over both shifts, and every combination of the two enables and the load select. Chained together, the two instances reach sixteen-bit shifts in both directions. In that chain a bit crosses the seam between the instances through the taps, which shows that tap timing and end ordering agree.

// File: rtl/bsr_pkg.sv
package bsr_pkg;
  typedef enum logic [1:0] {
    OP_HOLD = 2'b00,
    OP_UP   = 2'b01,
    OP_DOWN = 2'b10,
    OP_LOAD = 2'b11
  } bsr_op_e;
endpackage

// File: rtl/bsr_mode_decode.sv
module bsr_mode_decode
  import bsr_pkg::*;
(
  input  logic [1:0] sel,
  input  logic       oe_a_n,
  input  logic       oe_b_n,
  output bsr_op_e    op,
  output logic       drive_en
);
  always_comb begin
    op       = bsr_op_e'(sel);
    drive_en = !oe_a_n && !oe_b_n && (op != OP_LOAD);
  end
endmodule

// File: rtl/bsr_cell.sv
module bsr_cell
  import bsr_pkg::*;
(
  input  logic    clk,
  input  logic    clr_n,
  input  bsr_op_e op,
  input  logic    from_below,
  input  logic    from_above,
  input  logic    par_d,
  output logic    q
);
  always_ff @(posedge clk) begin
    if (!clr_n) begin
      q <= 1'b0;
    end else begin
      unique case (op)
        OP_HOLD: q <= q;
        OP_UP:   q <= from_below;
        OP_DOWN: q <= from_above;
        OP_LOAD: q <= par_d;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import bsr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         clr_n,
  input  logic [1:0]   sel,
  input  logic         ser_in_lo,
  input  logic         ser_in_hi,
  input  logic         oe_a_n,
  input  logic         oe_b_n,
  input  logic [W-1:0] bus_in,
  output logic [W-1:0] bus_out,
  output logic         bus_oe,
  output logic         tap_lo,
  output logic         tap_hi
);
  localparam int TOP = W - 1;

  bsr_op_e      op;
  logic [W-1:0] q;

  bsr_mode_decode u_dec (
    .sel      (sel),
    .oe_a_n   (oe_a_n),
    .oe_b_n   (oe_b_n),
    .op       (op),
    .drive_en (bus_oe)
  );

  for (genvar n = 0; n < W; n++) begin : g_bit
    logic below, above;
    if (n == 0) begin : g_lo_end
      assign below = ser_in_lo;
    end else begin : g_lo_mid
      assign below = q[n-1];
    end
    if (n == TOP) begin : g_hi_end
      assign above = ser_in_hi;
    end else begin : g_hi_mid
      assign above = q[n+1];
    end
    bsr_cell u_cell (
      .clk        (clk),
      .clr_n      (clr_n),
      .op         (op),
      .from_below (below),
      .from_above (above),
      .par_d      (bus_in[n]),
      .q          (q[n])
    );
  end

  assign bus_out = q;
  assign tap_lo  = q[0];
  assign tap_hi  = q[TOP];

  // Checking aid: becomes 1 once a clear has set a known state.
  logic armed = 1'b0;
  always_ff @(posedge clk) if (!clr_n) armed <= 1'b1;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!armed)
    !clr_n |=> (bus_out == '0)); // R1
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && sel == 2'b00) |=> $stable(bus_out)); // R2
  AST_MOVE_UP: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && sel == 2'b01) |=> (bus_out == {$past(bus_out[W-2:0]), $past(ser_in_lo)})); // R3
  AST_MOVE_DOWN: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && sel == 2'b10) |=> (bus_out == {$past(ser_in_hi), $past(bus_out[W-1:1])})); // R4
  AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && sel == 2'b11) |=> (bus_out == $past(bus_in))); // R5
  AST_LOAD_RELEASE: assert property (@(posedge clk) disable iff (!armed)
    (sel == 2'b11) |-> !bus_oe); // R6
  AST_ENABLE_RELEASE: assert property (@(posedge clk) disable iff (!armed)
    (oe_a_n || oe_b_n) |-> !bus_oe); // R6
  AST_TAPS_MATCH: assert property (@(posedge clk) disable iff (!armed)
    (tap_lo == bus_out[0]) && (tap_hi == bus_out[TOP])); // R7
endmodule

// File: tb/bidir_shift_reg_bench.sv
module bidir_shift_reg_bench;
  localparam int W = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic         clr_n = 1'b0;
  logic [1:0]   sel = 2'b00;
  logic         si_lo = 1'b0, si_hi = 1'b0;
  logic         oe_a_n = 1'b0, oe_b_n = 1'b0;
  logic [W-1:0] bin_a = '0, bin_b = '0;
  logic [W-1:0] bout_a, bout_b;
  logic         oe_a, oe_b;
  logic         tlo_a, thi_a, tlo_b, thi_b;

  bidir_shift_reg #(.W(W)) u_bidir_shift_reg (
    .clk(clk), .clr_n(clr_n), .sel(sel), .ser_in_lo(si_lo), .ser_in_hi(tlo_b),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .bus_in(bin_a), .bus_out(bout_a),
    .bus_oe(oe_a), .tap_lo(tlo_a), .tap_hi(thi_a));

  bidir_shift_reg #(.W(W)) u_bidir_shift_reg_hi (
    .clk(clk), .clr_n(clr_n), .sel(sel), .ser_in_lo(thi_a), .ser_in_hi(si_hi),
    .oe_a_n(oe_a_n), .oe_b_n(oe_b_n), .bus_in(bin_b), .bus_out(bout_b),
    .bus_oe(oe_b), .tap_lo(tlo_b), .tap_hi(thi_b));

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic load_a(input logic [W-1:0] v);
    clr_n = 1'b1; sel = 2'b11; bin_a = v;
    tick();
  endtask

  task automatic t_clear();
    clr_n = 1'b0; sel = 2'b11; bin_a = 8'hFF; si_lo = 1'b1;
    tick();
    chk("R1 clear over load", {24'd0, bout_a}, 32'h0);
    load_a(8'h5A);
    clr_n = 1'b0; sel = 2'b01; tick();
    chk("R1 clear over move up", {24'd0, bout_a}, 32'h0);
    load_a(8'hC3);
    clr_n = 1'b0; sel = 2'b10; tick();
    chk("R1 clear over move down", {24'd0, bout_a}, 32'h0);
    clr_n = 1'b1;
  endtask

  task automatic t_load_hold();
    oe_a_n = 1'b0; oe_b_n = 1'b0;
    load_a(8'hA5);
    chk("R5 load capture", {24'd0, bout_a}, 32'hA5);
    chk("R6 released during load", {31'd0, oe_a}, 32'd0);
    sel = 2'b00;
    for (int i = 0; i < 3; i++) begin
      bin_a = 8'h11 * i[7:0]; si_lo = i[0]; si_hi = ~i[0];
      tick();
      chk("R2 hold", {24'd0, bout_a}, 32'hA5);
    end
    chk("R6 driven in hold", {31'd0, oe_a}, 32'd1);
  endtask

  task automatic t_move_up();
    logic [W-1:0] e;
    load_a(8'h81); e = 8'h81;
    sel = 2'b01;
    for (int i = 0; i < 4; i++) begin
      si_lo = (i == 1 || i == 2);
      e = {e[W-2:0], si_lo};
      tick();
      chk("R3 move up", {24'd0, bout_a}, {24'd0, e});
    end
  endtask

  task automatic t_move_down();
    logic [W-1:0] e;
    clr_n = 1'b1; sel = 2'b11; bin_a = 8'h3C; bin_b = 8'h00;
    tick();
    e = 8'h3C; sel = 2'b10;
    // ser_in_hi of the low instance is tap_lo of the high one, held at 0
    for (int i = 0; i < 3; i++) begin
      e = {1'b0, e[W-1:1]};
      tick();
      chk("R4 move down", {24'd0, bout_a}, {24'd0, e});
    end
  endtask

  task automatic t_enables();
    for (int c = 0; c < 8; c++) begin
      oe_a_n = c[0]; oe_b_n = c[1]; sel = c[2] ? 2'b11 : 2'b01;
      #1;
      chk("R6 bus enable", {31'd0, oe_a}, {31'd0, (c == 0)});
    end
    sel = 2'b00; oe_a_n = 1'b1; oe_b_n = 1'b0;
    load_a(8'h81);
    chk("R7 taps and bus with release", {20'd0, tlo_a, thi_a, 2'b00, bout_a}, {20'd0, 4'b1100, 8'h81});
    sel = 2'b00; #1;
    chk("R6 released by enable A", {31'd0, oe_a}, 32'd0);
  endtask

  task automatic t_released_ops();
    oe_a_n = 1'b1; oe_b_n = 1'b1;
    load_a(8'h6E);
    chk("R8 load while released", {24'd0, bout_a}, 32'h6E);
    sel = 2'b01; si_lo = 1'b1; tick();
    chk("R8 move up while released", {24'd0, bout_a}, 32'hDD);
    clr_n = 1'b0; tick();
    chk("R8 clear while released", {24'd0, bout_a}, 32'h00);
    clr_n = 1'b1; oe_a_n = 1'b0; oe_b_n = 1'b0;
  endtask

  task automatic t_cascade();
    logic [2*W-1:0] e;
    clr_n = 1'b1; sel = 2'b11; bin_a = 8'h0F; bin_b = 8'hB0;
    tick();
    e = 16'hB00F;
    chk("R9 cascade load", {16'd0, bout_b, bout_a}, {16'd0, e});
    sel = 2'b01;
    for (int i = 0; i < 10; i++) begin
      si_lo = i[1];
      e = {e[2*W-2:0], si_lo};
      tick();
      chk("R9 cascade move up", {16'd0, bout_b, bout_a}, {16'd0, e});
    end
    sel = 2'b10;
    for (int i = 0; i < 10; i++) begin
      si_hi = i[0];
      e = {si_hi, e[2*W-1:1]};
      tick();
      chk("R9 cascade move down", {16'd0, bout_b, bout_a}, {16'd0, e});
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    #2;
    t_clear();
    t_load_hold();
    t_move_up();
    t_move_down();
    t_enables();
    t_released_ops();
    t_cascade();
    done = 1;
    summary();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      summary();
    end
  end
endmodule